// File: doc/BRIEF.md
# Register-Driven SPI Shift Engine

This block is a memory-mapped SPI master driven entirely through a small register bus. Software enables the engine, programs a clock divider, loads up to 32 bits of transmit data and then writes a single shift command. That command starts the transfer, picks which of three chip-select lines goes low, sets how many bits to move and says whether chip select is released when the last bit is done. The engine shifts MSB first in SPI mode 0. It clears the start bit by itself when the transfer is finished, and software polls that bit. Received bits are then read from a data-in register.

A transaction longer than 32 bits is built from several commands. Every command except the last leaves its terminate flag clear, so chip select stays low across the gaps between 32-bit chunks. When the engine is not enabled, the SPI pins follow an IO-control register. Its reset value keeps every chip select high and both clock and data low.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset, IO-control (offset 0x08) reads 0x0007_0000 and the engine is disabled. While it is disabled, the pins follow IO-control: `mosi` follows bit 0, `sck` follows bit 8 and `cs_n[i]` follows bit 16+i. Reset therefore leaves `cs_n`=3'b111, `sck`=0 and `mosi`=0.
- R2: Bit 0 of function-select (offset 0x00) enables the engine. A shift command written while it is 0 starts nothing, and the start bit reads back 0.
- R3: Writing shift-control (offset 0x14) with bit 31 set starts a shift. Bit 31 reads back 1 for exactly count×2×(div+1) clock cycles after the write edge, and then reads 0.
- R4: SCK idles low. During a shift, each half period of SCK lasts div+1 input clocks, where div is control bits [5:0] (offset 0x04). Each bit starts with its low half.
- R5: Transmit data comes from data-out (offset 0x10), starting at bit count−1 and moving down toward bit 0. `mosi` changes only at a falling SCK edge (or at the start) and holds steady while SCK is high.
- R6: `miso` is sampled at each rising SCK edge and enters data-in (offset 0x18) at bit 0, with older bits moving left. Data-in is cleared when a shift starts, so after the shift it holds the received bits right-aligned.
- R7: Shift-control bits 28, 29 and 30 drive `cs_n[0]`, `cs_n[1]` and `cs_n[2]` low while the engine is enabled. Each set bit asserts its own line and leaves the others high.
- R8: If shift-control bit 26 (terminate) is set, chip select goes high when the last bit ends. If it is clear, chip select stays low after the shift until a later command changes it.
- R9: A write to shift-control or data-out while a shift is in progress is ignored. Pins, timing and transmit bits continue unchanged, and shift-control reads back the original command.
- R10: The count is in shift-control bits [6:0]. A count of 0 completes at once: busy never rises and SCK does not toggle, but the chip-select hold or release still takes effect. A count above 32 is treated as 32.
- R11: Control reads back the divider in bits [5:0], function-select reads back the enable in bit 0, and data-out reads back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd`, zero otherwise |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI data toward the device |
| miso | input | 1 | SPI data from the device |
| cs_n | output | 3 | Active-low chip selects |

## Verification
The bench uses the default widths: a 32-bit data path, a 6-bit divider and three chip selects. Within those it drives dividers 0 through 3, so the checks see both the one-clock half period and longer ones, where mid-bit samples are checked. Transfers of 8, 16 and 32 bits, an oversized count of 40 and a zero count reach both ends of the count range. Chained commands with terminate clear exercise chip-select hold across chunks, and commands written in mid-transfer test the ignore rule.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam int XW     = 32;
    localparam int ADDR_W = 5;
    localparam int DIV_W  = 6;
    localparam int CNT_W  = 7;
    localparam int NUM_CS = 3;
    localparam int BITS_W = $clog2(XW) + 1;
    localparam int IDX_W  = $clog2(XW);

    localparam logic [ADDR_W-1:0] REG_FS    = 5'h00;
    localparam logic [ADDR_W-1:0] REG_CTRL  = 5'h04;
    localparam logic [ADDR_W-1:0] REG_IOC   = 5'h08;
    localparam logic [ADDR_W-1:0] REG_DOUT  = 5'h10;
    localparam logic [ADDR_W-1:0] REG_SHIFT = 5'h14;
    localparam logic [ADDR_W-1:0] REG_DIN   = 5'h18;

    localparam int SH_GO_BIT   = 31;
    localparam int SH_CS_LSB   = 28;
    localparam int SH_TERM_BIT = 26;
    localparam int IOC_DO_BIT  = 0;
    localparam int IOC_CLK_BIT = 8;
    localparam int IOC_CS_LSB  = 16;

    localparam logic [XW-1:0] IOC_RESET = 32'h0007_0000;

    typedef struct packed {
        logic [NUM_CS-1:0] sel;
        logic              term;
        logic [CNT_W-1:0]  cnt;
    } shift_cmd_t;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    function automatic shift_cmd_t unpack_cmd(input logic [XW-1:0] w);
        shift_cmd_t c;
        c.sel  = w[SH_CS_LSB +: NUM_CS];
        c.term = w[SH_TERM_BIT];
        c.cnt  = w[CNT_W-1:0];
        return c;
    endfunction

    function automatic logic [XW-1:0] pack_cmd(input shift_cmd_t c, input logic busy);
        logic [XW-1:0] w;
        w = '0;
        w[SH_GO_BIT]               = busy;
        w[SH_CS_LSB +: NUM_CS]     = c.sel;
        w[SH_TERM_BIT]             = c.term;
        w[CNT_W-1:0]               = c.cnt;
        return w;
    endfunction

    function automatic logic [BITS_W-1:0] eff_bits(input logic [CNT_W-1:0] c);
        if (c > CNT_W'(XW))
            return BITS_W'(XW);
        return BITS_W'(c);
    endfunction

endpackage

// File: rtl/spi_regs.sv
module spi_regs
    import spi_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [XW-1:0]     wdata,
    input  logic              busy,
    input  logic [XW-1:0]     dout_q,
    input  logic [XW-1:0]     din_q,
    output logic              en,
    output logic [DIV_W-1:0]  div,
    output logic [XW-1:0]     ioc,
    output shift_cmd_t        cmd_new,
    output logic              start,
    output logic              dout_load,
    output logic [XW-1:0]     rdata
);

    shift_cmd_t cmd_q;
    logic       shift_hit;

    assign shift_hit = wr && (addr == REG_SHIFT) && !busy;
    assign cmd_new   = unpack_cmd(wdata);
    assign start     = shift_hit && wdata[SH_GO_BIT] && en;
    assign dout_load = wr && (addr == REG_DOUT) && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            en    <= 1'b0;
            div   <= '0;
            ioc   <= IOC_RESET;
            cmd_q <= '0;
        end else begin
            if (wr && addr == REG_FS)
                en <= wdata[0];
            if (wr && addr == REG_CTRL)
                div <= wdata[DIV_W-1:0];
            if (wr && addr == REG_IOC)
                ioc <= wdata;
            if (shift_hit)
                cmd_q <= cmd_new;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            case (addr)
                REG_FS:    rdata = {{(XW-1){1'b0}}, en};
                REG_CTRL:  rdata = {{(XW-DIV_W){1'b0}}, div};
                REG_IOC:   rdata = ioc;
                REG_DOUT:  rdata = dout_q;
                REG_SHIFT: rdata = pack_cmd(cmd_q, busy);
                REG_DIN:   rdata = din_q;
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
    import spi_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  shift_cmd_t        cmd,
    input  logic [DIV_W-1:0]  div,
    input  logic              dout_load,
    input  logic [XW-1:0]     dout_wdata,
    input  logic              miso,
    output logic              busy,
    output logic              sck_eng,
    output logic              mosi_eng,
    output logic [NUM_CS-1:0] cs_act,
    output logic [XW-1:0]     dout_q,
    output logic [XW-1:0]     din_q
);

    logic [DIV_W-1:0]  hcnt;
    logic [DIV_W-1:0]  div_l;
    phase_e            ph;
    logic [BITS_W-1:0] rem;
    logic [IDX_W-1:0]  msb;
    logic              term_l;
    logic [BITS_W-1:0] n_start;
    logic              half_done;
    logic              rise_now;
    logic              fall_now;

    assign n_start   = eff_bits(cmd.cnt);
    assign half_done = (hcnt == div_l);
    assign rise_now  = busy && half_done && (ph == PH_LOW);
    assign fall_now  = busy && half_done && (ph == PH_HIGH);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            ph     <= PH_LOW;
            hcnt   <= '0;
            div_l  <= '0;
            rem    <= '0;
            msb    <= '0;
            term_l <= 1'b0;
            cs_act <= '0;
        end else if (start) begin
            ph   <= PH_LOW;
            hcnt <= '0;
            if (n_start == '0) begin
                busy   <= 1'b0;
                cs_act <= cmd.term ? '0 : cmd.sel;
            end else begin
                busy   <= 1'b1;
                cs_act <= cmd.sel;
                div_l  <= div;
                rem    <= n_start;
                msb    <= IDX_W'(n_start - BITS_W'(1));
                term_l <= cmd.term;
            end
        end else if (busy) begin
            if (half_done) begin
                hcnt <= '0;
                if (ph == PH_LOW) begin
                    ph <= PH_HIGH;
                end else begin
                    ph  <= PH_LOW;
                    rem <= rem - BITS_W'(1);
                    if (rem == BITS_W'(1)) begin
                        busy <= 1'b0;
                        if (term_l)
                            cs_act <= '0;
                    end
                end
            end else begin
                hcnt <= hcnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            dout_q <= '0;
        else if (dout_load)
            dout_q <= dout_wdata;
        else if (fall_now)
            dout_q <= {dout_q[XW-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst)
            din_q <= '0;
        else if (start)
            din_q <= '0;
        else if (rise_now)
            din_q <= {din_q[XW-2:0], miso};
    end

    assign sck_eng  = busy && (ph == PH_HIGH);
    assign mosi_eng = busy && dout_q[msb];

endmodule

// File: rtl/spi_pinmux.sv
module spi_pinmux
    import spi_eng_pkg::*;
(
    input  logic              en,
    input  logic [XW-1:0]     ioc,
    input  logic              sck_eng,
    input  logic              mosi_eng,
    input  logic [NUM_CS-1:0] cs_act,
    output logic              sck,
    output logic              mosi,
    output logic [NUM_CS-1:0] cs_n
);

    assign sck  = en ? sck_eng  : ioc[IOC_CLK_BIT];
    assign mosi = en ? mosi_eng : ioc[IOC_DO_BIT];

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n[i] = en ? ~cs_act[i] : ioc[IOC_CS_LSB + i];
    end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [XW-1:0]     bus_wdata,
    output logic [XW-1:0]     bus_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n
);

    logic              eng_en;
    logic              eng_busy;
    logic [DIV_W-1:0]  div;
    logic [XW-1:0]     ioc;
    shift_cmd_t        cmd_new;
    logic              start;
    logic              dout_load;
    logic [XW-1:0]     dout_q;
    logic [XW-1:0]     din_q;
    logic              sck_eng;
    logic              mosi_eng;
    logic [NUM_CS-1:0] cs_act;

    spi_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr      (bus_addr),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .wdata     (bus_wdata),
        .busy      (eng_busy),
        .dout_q    (dout_q),
        .din_q     (din_q),
        .en        (eng_en),
        .div       (div),
        .ioc       (ioc),
        .cmd_new   (cmd_new),
        .start     (start),
        .dout_load (dout_load),
        .rdata     (bus_rdata)
    );

    spi_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cmd        (cmd_new),
        .div        (div),
        .dout_load  (dout_load),
        .dout_wdata (bus_wdata),
        .miso       (miso),
        .busy       (eng_busy),
        .sck_eng    (sck_eng),
        .mosi_eng   (mosi_eng),
        .cs_act     (cs_act),
        .dout_q     (dout_q),
        .din_q      (din_q)
    );

    spi_pinmux u_pins (
        .en       (eng_en),
        .ioc      (ioc),
        .sck_eng  (sck_eng),
        .mosi_eng (mosi_eng),
        .cs_act   (cs_act),
        .sck      (sck),
        .mosi     (mosi),
        .cs_n     (cs_n)
    );

endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk
    import spi_eng_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              busy,
    input logic              sck,
    input logic              mosi,
    input logic [NUM_CS-1:0] cs_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [XW-1:0]     bus_wdata
);

    logic go_wr;
    assign go_wr = bus_wr && (bus_addr == REG_SHIFT) && bus_wdata[SH_GO_BIT] && en && !busy;

    // R4: the serial clock rests low whenever the engine is idle
    p_sck_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (en && !busy) |-> !sck);

    // R3: an accepted non-zero command raises busy on the next cycle
    p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (go_wr && bus_wdata[CNT_W-1:0] != '0) |=> busy);

    // R10: a zero count never raises busy
    p_zero_count_r10: assert property (@(posedge clk) disable iff (rst)
        (go_wr && bus_wdata[CNT_W-1:0] == '0) |=> !busy);

    // R9: chip selects cannot move while a shift runs
    p_cs_hold_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (en && busy) |=> (!busy || !en || $stable(cs_n)));

    // R5: transmit data is steady through the high half of SCK
    p_mosi_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (en && busy && sck) |=> (!sck || $stable(mosi)));

endmodule

bind spi_shift_engine spi_shift_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (eng_en),
    .busy      (eng_busy),
    .sck       (sck),
    .mosi      (mosi),
    .cs_n      (cs_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/spi_shift_engine_tb.sv
module spi_shift_engine_tb;
    import spi_eng_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [XW-1:0]     bus_wdata = '0;
    logic [XW-1:0]     bus_rdata;
    logic              sck;
    logic              mosi;
    logic              miso = 1'b0;
    logic [NUM_CS-1:0] cs_n;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_shift_engine u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sck       (sck),
        .mosi      (mosi),
        .miso      (miso),
        .cs_n      (cs_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        d        = bus_rdata;
        bus_rd   = 1'b0;
    endtask

    function automatic logic [31:0] shift_word(input bit go, input logic [2:0] sel,
                                               input bit term, input int cnt);
        logic [31:0] w;
        w = '0;
        w[31]    = go;
        w[30:28] = sel;
        w[26]    = term;
        w[6:0]   = 7'(cnt);
        return w;
    endfunction

    // Behavioural reference: per clock, expected SCK level, transmit bit and selects
    task automatic xfer(input int cnt_raw, input int dv, input logic [2:0] sel,
                        input bit term, input logic [31:0] dat, input logic [31:0] mpat,
                        input bit inject);
        int n;
        int hh;
        logic [31:0] got;
        logic [31:0] exp_din;
        n  = (cnt_raw > 32) ? 32 : cnt_raw;
        hh = dv + 1;
        bus_write(REG_CTRL, 32'(dv));
        bus_write(REG_DOUT, dat);
        bus_write(REG_SHIFT, shift_word(1, sel, term, cnt_raw));
        for (int b = 0; b < n; b++) begin
            for (int ph = 0; ph < 2; ph++) begin
                for (int h = 0; h < hh; h++) begin
                    bus_wr = 1'b0;
                    if (ph == 0 && h == 0)
                        miso = mpat[n-1-b];
                    check(sck == ph[0], "R4", "sck level", {31'b0, sck}, ph);
                    check(mosi == dat[n-1-b], "R5", "mosi bit", {31'b0, mosi}, {31'b0, dat[n-1-b]});
                    check(cs_n == ~sel, "R7", "cs_n during shift", {29'b0, cs_n}, {29'b0, ~sel});
                    if (b == 0 && ph == 0 && h == 0) begin
                        bus_read(REG_SHIFT, got);
                        check(got[31] == 1'b1, "R3", "busy at start", got, {1'b1, 31'b0});
                    end
                    if (b == n-1 && ph == 1 && h == hh-1) begin
                        bus_read(REG_SHIFT, got);
                        check(got[31] == 1'b1, "R3", "busy in last cycle", got, {1'b1, 31'b0});
                    end
                    if (inject && ph == 0 && h == 0 && b == 1) begin
                        bus_addr  = REG_SHIFT;
                        bus_wdata = shift_word(1, 3'b010, 1, 8);
                        bus_wr    = 1'b1;
                    end
                    if (inject && ph == 0 && h == 0 && b == 2) begin
                        bus_addr  = REG_DOUT;
                        bus_wdata = 32'hFFFF_FFFF;
                        bus_wr    = 1'b1;
                    end
                    @(negedge clk);
                end
            end
        end
        bus_wr = 1'b0;
        bus_read(REG_SHIFT, got);
        check(got[31] == 1'b0, "R3", "busy cleared after count", got, 32'h0);
        check(sck == 1'b0, "R4", "sck idle after", {31'b0, sck}, 32'h0);
        check(cs_n == (term ? 3'b111 : ~sel), "R8", "cs_n after shift",
              {29'b0, cs_n}, {29'b0, term ? 3'b111 : ~sel});
        exp_din = (n == 32) ? mpat : (mpat & ((32'h1 << n) - 32'h1));
        bus_read(REG_DIN, got);
        check(got == exp_din, "R6", "data-in", got, exp_din);
        if (inject) begin
            bus_read(REG_SHIFT, got);
            check(got[6:0] == 7'(cnt_raw) && got[30:28] == sel, "R9", "shift-ctrl kept",
                  got, shift_word(0, sel, term, cnt_raw));
        end
    endtask

    initial begin
        logic [31:0] got;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state of pins and IO-control
        check(cs_n == 3'b111, "R1", "cs_n reset", {29'b0, cs_n}, 32'h7);
        check(sck == 1'b0 && mosi == 1'b0, "R1", "sck/mosi reset", {30'b0, sck, mosi}, 32'h0);
        bus_read(REG_IOC, got);
        check(got == 32'h0007_0000, "R1", "IO-control reset", got, 32'h0007_0000);
        bus_read(REG_FS, got);
        check(got == 32'h0, "R2", "engine disabled at reset", got, 32'h0);

        // R1: pins follow IO-control while disabled
        bus_write(REG_IOC, 32'h0002_0101);
        check(cs_n == 3'b010 && sck == 1'b1 && mosi == 1'b1, "R1", "ioc drive",
              {27'b0, cs_n, sck, mosi}, {27'b0, 3'b010, 2'b11});
        bus_write(REG_IOC, 32'h0007_0000);

        // R2: start is dropped while disabled
        bus_write(REG_SHIFT, shift_word(1, 3'b001, 1, 8));
        repeat (3) begin
            check(sck == 1'b0 && cs_n == 3'b111, "R2", "no shift while disabled",
                  {28'b0, cs_n, sck}, 32'he);
            @(negedge clk);
        end
        bus_read(REG_SHIFT, got);
        check(got[31] == 1'b0, "R2", "start bit not held", got, {1'b0, got[30:0]});

        bus_write(REG_FS, 32'h1);
        bus_read(REG_FS, got);
        check(got == 32'h1, "R11", "function-select readback", got, 32'h1);
        bus_write(REG_CTRL, 32'h25);
        bus_read(REG_CTRL, got);
        check(got == 32'h25, "R11", "control readback", got, 32'h25);
        bus_write(REG_DOUT, 32'hCAFE_F00D);
        bus_read(REG_DOUT, got);
        check(got == 32'hCAFE_F00D, "R11", "data-out readback", got, 32'hCAFE_F00D);

        // R3 R4 R5 R6 R7 R8: assorted transfers
        xfer(8, 0, 3'b001, 1, 32'h0000_00A5, 32'h0000_003C, 0);
        xfer(16, 3, 3'b100, 1, 32'h0000_1234, 32'h0000_9E71, 0);
        // R8: hold chip select across chunks, then release
        xfer(32, 1, 3'b010, 0, 32'hDEAD_BEEF, 32'h8421_7BDE, 0);
        repeat (3) begin
            check(cs_n == 3'b101, "R8", "cs held between chunks", {29'b0, cs_n}, 32'h5);
            @(negedge clk);
        end
        xfer(8, 0, 3'b010, 1, 32'h0000_0081, 32'h0000_00FF, 0);
        // R9: writes during a shift are ignored
        xfer(16, 2, 3'b001, 1, 32'h0000_5A0F, 32'h0000_C3A5, 1);
        // R10: oversized count behaves as 32
        xfer(40, 0, 3'b100, 1, 32'h9876_5432, 32'h1357_9BDF, 0);

        // R10 R7: zero count with two selects, hold then release
        bus_write(REG_SHIFT, shift_word(1, 3'b011, 0, 0));
        bus_read(REG_SHIFT, got);
        check(got[31] == 1'b0, "R10", "zero count not busy", got, {1'b0, got[30:0]});
        repeat (3) begin
            check(sck == 1'b0 && cs_n == 3'b100, "R10", "zero count pins",
                  {28'b0, cs_n, sck}, 32'h8);
            @(negedge clk);
        end
        bus_write(REG_SHIFT, shift_word(1, 3'b011, 1, 0));
        check(cs_n == 3'b111, "R10", "zero count release", {29'b0, cs_n}, 32'h7);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule